// File: doc/BRIEF.md
# Wake Event Enable and Status Aggregator

This block collects sixteen wake sources into one shared, active-low wake request line for a power-management domain. Each source is edge-detected. Every rising edge is recorded in a sticky status bit, whether or not the source is enabled. Software can read these status bits and clear them by writing ones. The sources sit in two groups of eight. Each group has a status register and a matching enable register.

The wake line goes low only when three conditions hold together: at least one source is pending, that source's enable bit is set, and a single global wake-enable bit is set. The output is registered, so downstream logic never sees a combinational glitch.

All registers sit on a simple synchronous register bus with a 4-bit offset. Reads are combinational and have no side effects. Every register clears on the battery-backed power-on reset, which is the active-low `vbatRstN`.

Register offsets:

| Offset | Register | Contents |
|---|---|---|
| 0xB | Control | Global wake enable in bit 0 |
| 0xC | Status, group 0 | Sources 0 to 7 |
| 0xD | Status, group 1 | Sources 8 to 15 |
| 0xE | Enable, group 0 | Sources 0 to 7 |
| 0xF | Enable, group 1 | Sources 8 to 15 |

Group 0 bit assignment, bit 7 down to bit 0: device interrupt, real-time clock, ring-indicate pin, mouse, keyboard, serial ring 1, serial ring 2, infrared receiver. Group 1 carries general-purpose inputs 17 down to 10, in bits 7 down to 0.

Top module: `pm_wake_hub`

## Requirements
- R1: After reset, both enable registers, both status registers and the control register read 0x00, and `wakeN` is 1.
- R2: The enable registers at offset 0xE (sources 0-7, bit i = source i) and 0xF (sources 8-15, bit i = source 8+i) are read/write and read back the last value written.
- R3: A rising edge on `wakeSrc[i]` sets status bit i%8 of offset 0xC (i<8) or 0xD (i>=8) at the clock edge that samples it, regardless of the enable bit.
- R4: Writing a 1 to a status bit clears it; writing 0 leaves it unchanged.
- R5: When the control bit is 1 and any status bit is set together with its enable bit, `wakeN` is 0 one clock after that condition holds, and it returns to 1 one clock after the condition ends.
- R6: A pending source whose enable bit is 0 never drives `wakeN` low.
- R7: The global wake enable is bit 0 of offset 0xB, and the other bits read 0. While it is 0, `wakeN` stays 1 even with enabled pending sources.
- R8: Offsets 0x0 to 0xA read 0x00, and writes to them change no register and do not change `wakeN`.
- R9: If a rising edge and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: A source held high sets its status only once; after it is cleared, the status stays 0 until a new rising edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| vbatRstN | input | 1 | Battery-backed power-on reset, active low, asynchronous |
| busAddr | input | 4 | Register offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| wakeSrc | input | 16 | Wake source event levels, synchronous to `clk` |
| wakeN | output | 1 | Shared active-low wake request, registered |

## Verification
Status latching and status clearing can fall in the same cycle. The collision test first sets a status bit with a pulse. It then raises a fresh rising edge on that same source in the very cycle a write-1-to-clear for that bit is issued. The bit must read back as 1 afterwards. A second scenario separates the two cases: a source held high is cleared and must stay clear, which shows that a level alone never re-arms the bit.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned GRP_CNT   = 2;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned EN_OFS    = 14;
  localparam int unsigned STAT_OFS  = EN_OFS - GRP_CNT;
  localparam int unsigned CTL_OFS   = STAT_OFS - 1;
  localparam int unsigned SRC_CNT   = DATA_W * GRP_CNT;
  localparam int unsigned GRP_IDX_W = (GRP_CNT > 1) ? $clog2(GRP_CNT) : 1;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_EN   = 2'd1,
    RD_STAT = 2'd2,
    RD_CTL  = 2'd3
  } rdKindT;

  typedef struct packed {
    logic [GRP_CNT-1:0]   wrEn;
    logic [GRP_CNT-1:0]   clrSt;
    logic                 wrCtl;
    logic [DATA_W-1:0]    data;
    rdKindT               rdKind;
    logic [GRP_IDX_W-1:0] rdGrp;
  } regStrobeT;
endpackage

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_wake_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output regStrobeT         stb
);

  always_comb begin
    stb        = '0;
    stb.data   = busWrData;
    stb.rdKind = RD_NONE;
    for (int g = 0; g < int'(GRP_CNT); g++) begin
      if (busAddr == ADDR_W'(EN_OFS + g)) begin
        stb.rdKind  = RD_EN;
        stb.rdGrp   = GRP_IDX_W'(g);
        stb.wrEn[g] = busWrEn;
      end
      if (busAddr == ADDR_W'(STAT_OFS + g)) begin
        stb.rdKind   = RD_STAT;
        stb.rdGrp    = GRP_IDX_W'(g);
        stb.clrSt[g] = busWrEn;
      end
    end
    if (busAddr == ADDR_W'(CTL_OFS)) begin
      stb.rdKind = RD_CTL;
      stb.wrCtl  = busWrEn;
    end
  end

  always_comb begin
    AST_ONE_STROBE: assert ($onehot0({stb.wrEn, stb.clrSt, stb.wrCtl}))
      else $error("more than one register strobe"); // R8
  end

endmodule

// File: rtl/pm_wake_dpath.sv
module pm_wake_dpath
  import pm_wake_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobeT          stb,
  input  logic [SRC_CNT-1:0] wakeSrc,
  output logic [DATA_W-1:0]  rdData,
  output logic               wakeN
);

  logic [SRC_CNT-1:0] srcPrev;
  logic [SRC_CNT-1:0] riseVec;
  logic [SRC_CNT-1:0] clrVec;
  logic [GRP_CNT-1:0][DATA_W-1:0] enReg;
  logic [GRP_CNT-1:0][DATA_W-1:0] statReg;
  logic [SRC_CNT-1:0] enFlat;
  logic [SRC_CNT-1:0] statFlat;
  logic               globalEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcPrev <= '0;
    else       srcPrev <= wakeSrc;
  end

  assign riseVec  = wakeSrc & ~srcPrev;
  assign enFlat   = enReg;
  assign statFlat = statReg;

  for (genvar g = 0; g < GRP_CNT; g++) begin : gGrp
    assign clrVec[g*DATA_W +: DATA_W] = stb.clrSt[g] ? stb.data : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          enReg[g] <= '0;
      else if (stb.wrEn[g]) enReg[g] <= stb.data;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statReg[g] <= '0;
      else statReg[g] <= (statReg[g] & ~clrVec[g*DATA_W +: DATA_W])
                         | riseVec[g*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          globalEn <= 1'b0;
    else if (stb.wrCtl) globalEn <= stb.data[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeN <= 1'b1;
    else       wakeN <= ~(globalEn & |(statFlat & enFlat));
  end

  always_comb begin
    unique case (stb.rdKind)
      RD_EN:   rdData = enReg[stb.rdGrp];
      RD_STAT: rdData = statReg[stb.rdGrp];
      RD_CTL:  rdData = {{(DATA_W-1){1'b0}}, globalEn};
      default: rdData = '0;
    endcase
  end

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    (riseVec != '0) |=> ((statFlat & $past(riseVec)) == $past(riseVec))); // R3

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    ((clrVec & ~riseVec) != '0) |=> ((statFlat & $past(clrVec & ~riseVec)) == '0)); // R4

  AST_WAKE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (globalEn && ((statFlat & enFlat) != '0)) |=> !wakeN); // R5

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> wakeN); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((statFlat & enFlat) == '0) |=> wakeN); // R6

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn == '0) |=> $stable(enFlat)); // R8

endmodule

// File: rtl/pm_wake_hub.sv
module pm_wake_hub
  import pm_wake_pkg::*;
(
  input  logic               clk,
  input  logic               vbatRstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [SRC_CNT-1:0] wakeSrc,
  output logic               wakeN
);

  regStrobeT stb;

  pm_wake_ctrl i_ctrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .stb      (stb)
  );

  pm_wake_dpath i_dpath (
    .clk    (clk),
    .rstN   (vbatRstN),
    .stb    (stb),
    .wakeSrc(wakeSrc),
    .rdData (busRdData),
    .wakeN  (wakeN)
  );

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!vbatRstN)
    (busAddr < ADDR_W'(CTL_OFS)) |-> (busRdData == '0)); // R8

endmodule

// File: tb/test_pm_wake_hub.sv
module test_pm_wake_hub;
  import pm_wake_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        vbatRstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [15:0] wakeSrc = '0;
  logic        wakeN;

  int total = 0;
  int bad = 0;

  pm_wake_hub i_pm_wake_hub (
    .clk(clk), .vbatRstN(vbatRstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .wakeSrc(wakeSrc), .wakeN(wakeN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic pulseSrc(input int idx);
    @(negedge clk); wakeSrc[idx] = 1'b1;
    @(negedge clk); wakeSrc[idx] = 1'b0;
  endtask

  task automatic cleanUp();
    busWrite(4'hE, 8'h00); busWrite(4'hF, 8'h00);
    busWrite(4'hC, 8'hFF); busWrite(4'hD, 8'hFF);
    busWrite(4'hB, 8'h00);
    @(negedge clk);
  endtask

  task automatic tReset();
    logic [7:0] d;
    for (int a = 11; a < 16; a++) begin
      busRead(4'(a), d); chk("R1 reset reg", d, 8'h00);
    end
    chk("R1 reset wakeN", {7'b0, wakeN}, 8'h01);
  endtask

  task automatic tEnableRw();
    logic [7:0] d;
    busWrite(4'hE, 8'hA5); busWrite(4'hF, 8'h3C);
    busRead(4'hE, d); chk("R2 enable grp0", d, 8'hA5);
    busRead(4'hF, d); chk("R2 enable grp1", d, 8'h3C);
    cleanUp();
  endtask

  task automatic tDisabledStatus();
    logic [7:0] d;
    busWrite(4'hB, 8'h01);
    pulseSrc(5); pulseSrc(14);
    busRead(4'hC, d); chk("R3 status grp0", d, 8'h20);
    busRead(4'hD, d); chk("R3 status grp1", d, 8'h40);
    repeat (3) @(negedge clk);
    chk("R6 disabled no wake", {7'b0, wakeN}, 8'h01);
    cleanUp();
  endtask

  task automatic tClear();
    logic [7:0] d;
    pulseSrc(5); pulseSrc(2);
    busWrite(4'hC, 8'h00);
    busRead(4'hC, d); chk("R4 write0 no effect", d, 8'h24);
    busWrite(4'hC, 8'h20);
    busRead(4'hC, d); chk("R4 write1 clears", d, 8'h04);
    cleanUp();
  endtask

  task automatic tWake();
    busWrite(4'hF, 8'h10); busWrite(4'hB, 8'h01);
    pulseSrc(12);
    chk("R5 wake registered delay", {7'b0, wakeN}, 8'h01);
    @(negedge clk);
    chk("R5 wake asserted", {7'b0, wakeN}, 8'h00);
    busWrite(4'hD, 8'h10);
    chk("R5 wake held one cycle", {7'b0, wakeN}, 8'h00);
    @(negedge clk);
    chk("R5 wake released", {7'b0, wakeN}, 8'h01);
    cleanUp();
  endtask

  task automatic tGlobal();
    logic [7:0] d;
    busWrite(4'hE, 8'h80);
    pulseSrc(7);
    repeat (2) @(negedge clk);
    chk("R7 global off", {7'b0, wakeN}, 8'h01);
    busWrite(4'hB, 8'hFF);
    busRead(4'hB, d); chk("R7 ctl readback", d, 8'h01);
    @(negedge clk);
    chk("R7 global on", {7'b0, wakeN}, 8'h00);
    cleanUp();
  endtask

  task automatic tUnmapped();
    logic [7:0] d;
    busWrite(4'hE, 8'h0F); busWrite(4'hF, 8'hF0);
    busWrite(4'h5, 8'hFF); busWrite(4'hA, 8'hFF); busWrite(4'h0, 8'hFF);
    for (int a = 0; a < 11; a++) begin
      busRead(4'(a), d); chk("R8 unmapped read", d, 8'h00);
    end
    busRead(4'hE, d); chk("R8 enable grp0 kept", d, 8'h0F);
    busRead(4'hF, d); chk("R8 enable grp1 kept", d, 8'hF0);
    busRead(4'hB, d); chk("R8 ctl kept", d, 8'h00);
    chk("R8 wakeN kept", {7'b0, wakeN}, 8'h01);
    cleanUp();
  endtask

  task automatic tCollision();
    logic [7:0] d;
    pulseSrc(3);
    @(negedge clk);
    busAddr = 4'hC; busWrData = 8'h08; busWrEn = 1'b1; wakeSrc[3] = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; wakeSrc[3] = 1'b0;
    busRead(4'hC, d); chk("R9 set beats clear", d, 8'h08);
    cleanUp();
  endtask

  task automatic tLevel();
    logic [7:0] d;
    @(negedge clk); wakeSrc[9] = 1'b1;
    @(negedge clk);
    busRead(4'hD, d); chk("R10 first edge sets", d, 8'h02);
    busWrite(4'hD, 8'h02);
    repeat (3) @(negedge clk);
    busRead(4'hD, d); chk("R10 level no reset", d, 8'h00);
    wakeSrc[9] = 1'b0;
    cleanUp();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vbatRstN = 1'b1;
    @(negedge clk);
    tReset();
    tEnableRw();
    tDisabledStatus();
    tClear();
    tWake();
    tGlobal();
    tUnmapped();
    tCollision();
    tLevel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule